// File: doc/BRIEF.md
# Single-Level Page Address Translator

This block turns a 16-bit virtual address into a 22-bit physical address through a page table that is held in on-chip registers. Pages are 8 KB. The low 13 address bits are the byte offset and pass through unchanged. The top 3 bits select one of eight table entries. Each entry supplies a 9-bit frame number and a set of flags: present, read, write and execute permissions, a referenced marker and a dirty marker.

Every lookup is checked against the entry. An access to a page that is not present faults as unmapped. An access whose kind the entry does not permit faults as a permission violation. A write to a read-only shared page is reported this way, and system software can use that fault to make a private copy of the page. When an access is allowed, the entry's referenced marker is set, and a write also sets the dirty marker. Software reloads entries through a table write port, for example on a context switch. It reads the markers back through a status port.

Responses come from a small state machine with three states. `RS_IDLE` means no response is pending. `RS_GRANT` means the last request was translated. `RS_DENY` means the last request faulted. On every clock the next state is chosen from the current request alone. With no request the machine goes to `RS_IDLE`. A permitted request takes it to `RS_GRANT`, and a faulting request takes it to `RS_DENY`. Any state can move to any other state.

Top module: `vpage_xlate`

## Requirements
- R1: After reset every entry is not present and has both markers clear, and `rsp_valid` is 0 until a request is made.
- R2: A request sampled at a clock edge yields `rsp_valid`=1 after that edge. A permitted access returns `rsp_paddr` = {entry frame number, virtual address bits 12:0}, with `rsp_fault`=0 and `rsp_cause`=2'b00.
- R3: An access to an entry whose present bit is 0 returns `rsp_fault`=1 and `rsp_cause`=2'b01.
- R4: `req_kind` is encoded 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. A present entry that lacks the matching permission, or any reserved-kind access, returns `rsp_fault`=1 and `rsp_cause`=2'b10. Every faulting response drives `rsp_paddr` to 0.
- R5: When an entry is both not present and lacking permission, the cause is 2'b01 (unmapped wins).
- R6: A permitted access sets the entry's referenced marker. A permitted write also sets its dirty marker, and a permitted read or execute leaves the dirty marker unchanged.
- R7: A faulting access changes neither marker of any entry.
- R8: A table write loads frame, present and permissions for `tw_idx` and clears both markers. A lookup of the same entry in the same cycle uses the old contents, and the new contents apply from the next cycle.
- R9: In a cycle with no request, the following cycle shows `rsp_valid`=0.
- R10: When a table write and a permitted lookup hit the same entry in the same cycle, the table write wins, so both markers end up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 3 | Entry to load |
| tw_frame | input | 9 | Frame number to load |
| tw_valid | input | 1 | Present bit to load |
| tw_rd | input | 1 | Read permission to load |
| tw_wr | input | 1 | Write permission to load |
| tw_ex | input | 1 | Execute permission to load |
| st_idx | input | 3 | Entry whose markers are shown |
| st_ref | output | 1 | Referenced marker of entry `st_idx` |
| st_mod | output | 1 | Dirty marker of entry `st_idx` |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | 00 none, 01 unmapped, 10 permission |
| rsp_paddr | output | 22 | Physical address, 0 on fault |

## Verification
The bench builds the block with its default widths: a 16-bit virtual address, a 22-bit physical address and a 13-bit offset, which give eight entries and 9-bit frames. At these values the highest page index and an all-ones frame can be reached directly, so the concatenation is exercised at both ends of the address range. Every entry can also be tested for a same-cycle collision between a reload and a lookup. The access kinds, including the reserved one, are driven against entries whose permission sets differ, so that each fault cause and its priority can be seen at the ports.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_UNMAPPED = 2'b01,
        CAUSE_PERM     = 2'b10
    } cause_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'b00,
        RS_GRANT = 2'b01,
        RS_DENY  = 2'b10
    } rsp_state_t;

    typedef struct packed {
        logic present;
        logic can_rd;
        logic can_wr;
        logic can_ex;
        logic touched;
        logic dirty;
    } pte_flags_t;

endpackage

// File: rtl/vpx_table.sv
module vpx_table
    import vpx_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [FRAME_W-1:0] lk_frame,
    output pte_flags_t         lk_flags,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_dirty,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [FRAME_W-1:0] tw_frame,
    input  logic               tw_valid,
    input  logic               tw_rd,
    input  logic               tw_wr,
    input  logic               tw_ex,
    input  logic [IDX_W-1:0]   st_idx,
    output logic               st_ref,
    output logic               st_mod
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [FRAME_W-1:0] frame_q [ENTRIES];
    pte_flags_t         flags_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic load_hit;
        logic upd_hit;
        assign load_hit = tw_en  && (tw_idx  == IDX_W'(g));
        assign upd_hit  = upd_en && (upd_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frame_q[g] <= '0;
                flags_q[g] <= '0;
            end else if (load_hit) begin
                frame_q[g]         <= tw_frame;
                flags_q[g].present <= tw_valid;
                flags_q[g].can_rd  <= tw_rd;
                flags_q[g].can_wr  <= tw_wr;
                flags_q[g].can_ex  <= tw_ex;
                flags_q[g].touched <= 1'b0;
                flags_q[g].dirty   <= 1'b0;
            end else if (upd_hit) begin
                flags_q[g].touched <= 1'b1;
                if (upd_dirty) begin
                    flags_q[g].dirty <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        lk_frame = frame_q[lk_idx];
        lk_flags = flags_q[lk_idx];
        st_ref   = flags_q[st_idx].touched;
        st_mod   = flags_q[st_idx].dirty;
    end

endmodule

// File: rtl/vpx_check.sv
module vpx_check
    import vpx_pkg::*;
(
    input  pte_flags_t flags,
    input  acc_kind_t  kind,
    output logic       grant,
    output cause_t     cause
);

    logic allowed;

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = flags.can_rd;
            ACC_WRITE: allowed = flags.can_wr;
            ACC_EXEC:  allowed = flags.can_ex;
            default:   allowed = 1'b0;
        endcase

        if (!flags.present) begin
            cause = CAUSE_UNMAPPED;
        end else if (!allowed) begin
            cause = CAUSE_PERM;
        end else begin
            cause = CAUSE_NONE;
        end
        grant = (cause == CAUSE_NONE);
    end

endmodule

// File: rtl/vpx_rsp_fsm.sv
module vpx_rsp_fsm
    import vpx_pkg::*;
#(
    parameter int FRAME_W = 9,
    parameter int OFF_W   = 13,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               grant,
    input  cause_t             cause_in,
    input  logic [FRAME_W-1:0] frame,
    input  logic [OFF_W-1:0]   offset,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    output logic [PA_W-1:0]    rsp_paddr
);

    rsp_state_t         state_q;
    rsp_state_t         state_d;
    logic [PA_W-1:0]    paddr_q;
    cause_t             cause_q;

    always_comb begin
        if (!req_valid) begin
            state_d = RS_IDLE;
        end else if (grant) begin
            state_d = RS_GRANT;
        end else begin
            state_d = RS_DENY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                paddr_q <= {frame, offset};
                cause_q <= cause_in;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RS_GRANT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b0;
                rsp_cause = CAUSE_NONE;
                rsp_paddr = paddr_q;
            end
            RS_DENY: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_cause = cause_q;
                rsp_paddr = '0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_fault = 1'b0;
                rsp_cause = CAUSE_NONE;
                rsp_paddr = '0;
            end
        endcase
    end

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
    import vpx_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int PA_W  = 22,
    parameter int OFF_W = 13,
    localparam int VPN_W   = VA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic               tw_en,
    input  logic [VPN_W-1:0]   tw_idx,
    input  logic [FRAME_W-1:0] tw_frame,
    input  logic               tw_valid,
    input  logic               tw_rd,
    input  logic               tw_wr,
    input  logic               tw_ex,
    input  logic [VPN_W-1:0]   st_idx,
    output logic               st_ref,
    output logic               st_mod,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    output logic [PA_W-1:0]    rsp_paddr
);

    logic [VPN_W-1:0]   vpn;
    logic [OFF_W-1:0]   offset;
    acc_kind_t          kind;
    logic [FRAME_W-1:0] lk_frame;
    pte_flags_t         lk_flags;
    logic               grant;
    cause_t             cause;
    logic               upd_en;
    logic               upd_dirty;

    assign vpn       = req_vaddr[VA_W-1:OFF_W];
    assign offset    = req_vaddr[OFF_W-1:0];
    assign kind      = acc_kind_t'(req_kind);
    assign upd_en    = req_valid && grant;
    assign upd_dirty = (kind == ACC_WRITE);

    vpx_table #(
        .IDX_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (vpn),
        .lk_frame  (lk_frame),
        .lk_flags  (lk_flags),
        .upd_en    (upd_en),
        .upd_idx   (vpn),
        .upd_dirty (upd_dirty),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_frame  (tw_frame),
        .tw_valid  (tw_valid),
        .tw_rd     (tw_rd),
        .tw_wr     (tw_wr),
        .tw_ex     (tw_ex),
        .st_idx    (st_idx),
        .st_ref    (st_ref),
        .st_mod    (st_mod)
    );

    vpx_check u_check (
        .flags (lk_flags),
        .kind  (kind),
        .grant (grant),
        .cause (cause)
    );

    vpx_rsp_fsm #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .grant     (grant),
        .cause_in  (cause),
        .frame     (lk_frame),
        .offset    (offset),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/vpx_sva.sv
module vpx_sva #(
    parameter int VA_W  = 16,
    parameter int PA_W  = 22,
    parameter int OFF_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [1:0]      rsp_cause,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            st_ref,
    input logic            st_mod
);

    // R2: each request is answered in the next cycle
    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: a granted answer keeps the offset of the request
    p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R9: no request, no answer
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: a fault carries a nonzero cause and a zero address
    p_fault_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_cause != 2'b00 && rsp_paddr == '0));

    // R2: a granted answer carries no cause
    p_clean_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'b00));

    // R6: a dirty entry is always also referenced
    p_dirty_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_mod |-> st_ref);

endmodule

bind vpage_xlate vpx_sva #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr),
    .st_ref    (st_ref),
    .st_mod    (st_mod)
);

// File: tb/sim_vpage_xlate.sv
module sim_vpage_xlate;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        tw_en = 1'b0;
    logic [2:0]  tw_idx = '0;
    logic [8:0]  tw_frame = '0;
    logic        tw_valid = 1'b0;
    logic        tw_rd = 1'b0;
    logic        tw_wr = 1'b0;
    logic        tw_ex = 1'b0;
    logic [2:0]  st_idx = '0;
    logic        st_ref;
    logic        st_mod;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [21:0] rsp_paddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpage_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_frame(tw_frame),
        .tw_valid(tw_valid), .tw_rd(tw_rd), .tw_wr(tw_wr), .tw_ex(tw_ex),
        .st_idx(st_idx), .st_ref(st_ref), .st_mod(st_mod),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [8:0] fr,
                        input logic v, input logic r, input logic w, input logic x);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = idx; tw_frame = fr;
        tw_valid = v; tw_rd = r; tw_wr = w; tw_ex = x;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    // one request; outputs sampled at the negedge after the capturing edge
    task automatic access(input logic [15:0] va, input logic [1:0] kd);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic f, input logic [1:0] c,
                              input logic [21:0] pa);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(f));
        chk({tag, " cause"}, 32'(rsp_cause), 32'(c));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    task automatic expect_marks(input string tag, input logic [2:0] idx,
                                input logic r, input logic m);
        st_idx = idx;
        #1;
        chk({tag, " ref"}, 32'(st_ref), 32'(r));
        chk({tag, " mod"}, 32'(st_mod), 32'(m));
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < 8; i++) begin
            expect_marks("R1 markers clear", 3'(i), 1'b0, 1'b0);
        end
        access({3'd5, 13'h0010}, 2'b00);
        expect_rsp("R1 R3 unloaded entry", 1'b1, 2'b01, 22'h0);
    endtask

    task automatic t_translate();
        load(3'd2, 9'h1A5, 1'b1, 1'b1, 1'b1, 1'b0);
        access({3'd2, 13'h0ABC}, 2'b00);
        expect_rsp("R2 read", 1'b0, 2'b00, {9'h1A5, 13'h0ABC});
        expect_marks("R6 after read", 3'd2, 1'b1, 1'b0);
        access({3'd2, 13'h1FFF}, 2'b01);
        expect_rsp("R2 write", 1'b0, 2'b00, {9'h1A5, 13'h1FFF});
        expect_marks("R6 after write", 3'd2, 1'b1, 1'b1);
        load(3'd7, 9'h1FF, 1'b1, 1'b1, 1'b1, 1'b1);
        access(16'hFFFF, 2'b10);
        expect_rsp("R2 top page exec", 1'b0, 2'b00, 22'h3FFFFF);
        load(3'd0, 9'h000, 1'b1, 1'b1, 1'b0, 1'b0);
        access(16'h0000, 2'b00);
        expect_rsp("R2 page zero", 1'b0, 2'b00, 22'h0);
    endtask

    task automatic t_idle();
        access({3'd2, 13'h0004}, 2'b00);
        @(negedge clk);
        chk("R9 idle cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_protect();
        load(3'd3, 9'h0F0, 1'b1, 1'b1, 1'b0, 1'b0);
        access({3'd3, 13'h0020}, 2'b01);
        expect_rsp("R4 write to read-only", 1'b1, 2'b10, 22'h0);
        expect_marks("R7 after write fault", 3'd3, 1'b0, 1'b0);
        access({3'd3, 13'h0020}, 2'b10);
        expect_rsp("R4 exec denied", 1'b1, 2'b10, 22'h0);
        access({3'd7, 13'h0020}, 2'b11);
        expect_rsp("R4 reserved kind", 1'b1, 2'b10, 22'h0);
        expect_marks("R7 reserved leaves marks", 3'd7, 1'b1, 1'b0);
        access({3'd3, 13'h0020}, 2'b00);
        expect_rsp("R4 read allowed", 1'b0, 2'b00, {9'h0F0, 13'h0020});
        expect_marks("R6 read keeps clean", 3'd3, 1'b1, 1'b0);
    endtask

    task automatic t_priority();
        load(3'd4, 9'h055, 1'b0, 1'b0, 1'b0, 1'b0);
        access({3'd4, 13'h0001}, 2'b01);
        expect_rsp("R5 unmapped over perm", 1'b1, 2'b01, 22'h0);
        load(3'd4, 9'h055, 1'b0, 1'b1, 1'b1, 1'b1);
        access({3'd4, 13'h0001}, 2'b00);
        expect_rsp("R3 not present with perms", 1'b1, 2'b01, 22'h0);
        expect_marks("R7 after unmapped", 3'd4, 1'b0, 1'b0);
    endtask

    task automatic t_collide();
        load(3'd6, 9'h011, 1'b1, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = 3'd6; tw_frame = 9'h022;
        tw_valid = 1'b1; tw_rd = 1'b1; tw_wr = 1'b0; tw_ex = 1'b0;
        req_valid = 1'b1; req_vaddr = {3'd6, 13'h0100}; req_kind = 2'b01;
        @(negedge clk);
        tw_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R8 same-cycle uses old entry", 1'b0, 2'b00, {9'h011, 13'h0100});
        expect_marks("R10 reload beats update", 3'd6, 1'b0, 1'b0);
        access({3'd6, 13'h0100}, 2'b01);
        expect_rsp("R8 new perms next cycle", 1'b1, 2'b10, 22'h0);
        access({3'd6, 13'h0100}, 2'b00);
        expect_rsp("R8 new frame next cycle", 1'b0, 2'b00, {9'h022, 13'h0100});
        expect_marks("R8 reload clears", 3'd2, 1'b1, 1'b1);
        load(3'd2, 9'h1A5, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_marks("R8 reload clears markers", 3'd2, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_idle();
        t_protect();
        t_priority();
        t_collide();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule